// File: doc/BRIEF.md
# Serial ADC Frame Classifier

This block listens, without driving anything, to the chip-select, serial clock and data-out wires of a 12-bit serial converter link. All three lines are brought into the system clock domain through two-flop synchronisers. While chip-select is low the block counts rising serial clock edges and shifts in one data bit on each of them, most significant bit first.

When chip-select returns high, the block decides what kind of access the frame was. The decision uses only the clock count and whether the captured word is all ones. A frame can be a normal conversion, a power-down entry or a power-up dummy read. The block also rates the frame as complete, incomplete or invalid. It then presents the mode, the rating and the captured 12-bit word, together with a done pulse that lasts one cycle. Every result stays on the outputs until the next frame is evaluated.

Top module: `adc_frame_monitor`

## Requirements
- R1: After reset, mode, status and sample all read 0 and done is low.
- R2: Each synchronised rising serial clock edge inside a frame shifts one data bit in, MSB first. The sample is the last 12 bits captured. If fewer than 12 bits arrived, the unused upper bits are zero.
- R3: A frame with fewer than 10 clocks, zero included, reports mode 1 (power-down) and status 0 (invalid).
- R4: A frame with 10 or more clocks whose sample equals 0xFFF reports mode 2 (power-up) and status 0 (invalid).
- R5: Any other frame with exactly 16 clocks reports mode 0 (normal) and status 2 (complete).
- R6: Any other frame with 10 to 15 clocks reports mode 0 (normal) and status 1 (incomplete).
- R7: The clock counter stops at 31. Any other frame with more than 16 clocks reports mode 0 (normal) and status 0 (invalid).
- R8: Each chip-select rise that follows a chip-select fall produces exactly one done pulse, one system clock long. Serial clock activity while chip-select is high produces no pulse and has no effect on the next frame.
- R9: Between done pulses, mode, status and sample stay unchanged.
- R10: Every frame starts with a cleared counter and shift register, so nothing from the previous frame appears in its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Monitored chip-select, active low |
| sclk | input | 1 | Monitored serial clock |
| sdata | input | 1 | Monitored converter data output |
| mode | output | 2 | 0 normal, 1 power-down, 2 power-up |
| status | output | 2 | 0 invalid, 1 incomplete, 2 complete |
| sample | output | 12 | Captured conversion word |
| done | output | 1 | One-cycle pulse when a frame has been evaluated |

## Verification
Some rules hold on every cycle, and the assertions check those. The pulse is one cycle long and only appears after a frame was opened. The outputs hold steady between pulses. A power-down or power-up report always comes with the invalid status. A power-up report always carries an all-ones sample, and the complete status only appears with the normal mode. Other behaviour only shows when the bench drives whole frames and compares against its own model. That covers the exact count thresholds at 9/10, 15/16 and beyond 16, saturation on a 40-clock frame, the 10-clock all-ones word that must not count as power-up, zero-filling of short frames, and idle clocks with chip-select high leaving no trace.

// File: rtl/adc_frame_monitor.sv
module adc_frame_monitor #(
  parameter int DATA_W    = 12,
  parameter int CNT_W     = 5,
  parameter int MIN_CLKS  = 10,
  parameter int FULL_CLKS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              sdata,
  output logic [1:0]        mode,
  output logic [1:0]        status,
  output logic [DATA_W-1:0] sample,
  output logic              done
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_MIN = CNT_W'(MIN_CLKS);
  localparam logic [CNT_W-1:0] CNT_FUL = CNT_W'(FULL_CLKS);
  localparam logic [1:0] M_NORM = 2'd0, M_PDN = 2'd1, M_PUP = 2'd2;
  localparam logic [1:0] S_INV = 2'd0, S_INC = 2'd1, S_CMP = 2'd2;

  logic [2:0]        cs_q, ck_q;
  logic [1:0]        sd_q;
  logic              in_frame;
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] shreg;
  logic [1:0]        mode_n, status_n;

  wire cs_fall = cs_q[2] & ~cs_q[1];
  wire cs_rise = ~cs_q[2] & cs_q[1];
  wire ck_rise = ~ck_q[2] & ck_q[1];
  wire finish  = cs_rise & in_frame;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cs_q <= '1;
      ck_q <= '0;
      sd_q <= '0;
    end else begin
      cs_q <= {cs_q[1:0], cs_n};
      ck_q <= {ck_q[1:0], sclk};
      sd_q <= {sd_q[0], sdata};
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      in_frame <= 1'b0;
      cnt      <= '0;
      shreg    <= '0;
    end else if (cs_fall) begin
      in_frame <= 1'b1;
      cnt      <= '0;
      shreg    <= '0;
    end else if (finish) begin
      in_frame <= 1'b0;
      cnt      <= '0;
      shreg    <= '0;
    end else if (in_frame && ck_rise) begin
      shreg <= {shreg[DATA_W-2:0], sd_q[1]};
      if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
    end

  always_comb begin
    mode_n   = M_NORM;
    status_n = S_INV;
    if (cnt < CNT_MIN)
      mode_n = M_PDN;
    else if (&shreg)
      mode_n = M_PUP;
    else if (cnt == CNT_FUL)
      status_n = S_CMP;
    else if (cnt < CNT_FUL)
      status_n = S_INC;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      done   <= 1'b0;
      mode   <= M_NORM;
      status <= S_INV;
      sample <= '0;
    end else begin
      done <= finish;
      if (finish) begin
        mode   <= mode_n;
        status <= status_n;
        sample <= shreg;
      end
    end

  // R8
  done_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R8
  done_after_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(in_frame));
  // R9
  hold_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(mode) && $stable(status) && $stable(sample)));
  // R3
  pdn_invalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_PDN) |-> (status == S_INV));
  // R4
  pup_allones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_PUP) |-> (status == S_INV && &sample));
  // R5
  cmp_normal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status == S_CMP) |-> (mode == M_NORM));
  // R7
  cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CNT_MAX && in_frame && !cs_rise && !cs_fall) |=> (cnt == CNT_MAX));
endmodule

// File: tb/test_adc_frame_monitor.sv
module test_adc_frame_monitor;
  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sclk = 1'b0, sdata = 1'b0;
  logic [1:0] mode, status;
  logic [11:0] sample;
  logic done;
  int n_tests = 0, n_fail = 0;
  int done_cnt = 0, hold_err = 0;
  logic [1:0] l_mode, l_status;
  logic [11:0] l_sample;
  logic [15:0] prev_out;

  always #2 clk = ~clk;

  adc_frame_monitor i_adc_frame_monitor (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdata(sdata),
    .mode(mode), .status(status), .sample(sample), .done(done));

  always @(posedge clk) begin
    #1;
    if (rst_n) begin
      if (done) begin
        done_cnt++;
        l_mode = mode; l_status = status; l_sample = sample;
      end else if ({mode, status, sample} != prev_out) hold_err++;
    end
    prev_out = {mode, status, sample};
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic frame(input int nclk, input logic [31:0] vec, input string tag);
    int em, es, esm;
    done_cnt = 0; hold_err = 0;
    cs_n = 1'b0; waitc(6);
    for (int i = 0; i < nclk; i++) begin
      int p;
      p = nclk - 1 - i;
      sdata = (p < 32) ? vec[p] : 1'b0;
      waitc(4); sclk = 1'b1; waitc(4); sclk = 1'b0;
    end
    waitc(4); cs_n = 1'b1; waitc(10);
    esm = (nclk >= 12) ? int'(vec[11:0]) : int'(vec[11:0] & ((12'd1 << nclk) - 12'd1));
    if (nclk < 10) begin em = 1; es = 0; end
    else if (esm == 12'hFFF) begin em = 2; es = 0; end
    else if (nclk == 16) begin em = 0; es = 2; end
    else if (nclk < 16) begin em = 0; es = 1; end
    else begin em = 0; es = 0; end
    chk(done_cnt == 1, {tag, " R8 done pulses"}, done_cnt, 1);
    chk(int'(l_mode) == em, {tag, " mode"}, l_mode, em);
    chk(int'(l_status) == es, {tag, " status"}, l_status, es);
    chk(int'(l_sample) == esm, {tag, " R2 sample"}, l_sample, esm);
    chk(hold_err == 0, {tag, " R9 hold"}, hold_err, 0);
    waitc(8);
  endtask

  initial begin
    waitc(3);
    // R1 reset state
    chk(mode == 2'd0, "R1 mode", mode, 0);
    chk(status == 2'd0, "R1 status", status, 0);
    chk(sample == 12'd0, "R1 sample", sample, 0);
    chk(done == 1'b0, "R1 done", done, 0);
    rst_n = 1'b1; waitc(6);
    frame(16, 32'h0A5C, "R5 full");
    frame(16, 32'h0FFF, "R4 pup16");
    frame(12, 32'h0FFF, "R4 pup12");
    frame(10, 32'h03FF, "R6 ones10");
    frame(15, 32'h1234, "R6 n15");
    frame(10, 32'h0155, "R6 n10");
    frame(9, 32'h01FF, "R3 n9");
    frame(0, 32'h0, "R3 zero");
    frame(17, 32'h1ABCD, "R7 n17");
    frame(40, 32'hDEAD0123, "R7 n40");
    frame(5, 32'h15, "R10 fresh");
    // R8 idle clocks with cs high: no pulse, and no effect on next frame
    done_cnt = 0; hold_err = 0;
    for (int i = 0; i < 6; i++) begin
      sdata = 1'b1; waitc(4); sclk = 1'b1; waitc(4); sclk = 1'b0;
    end
    waitc(10);
    chk(done_cnt == 0, "R8 idle no done", done_cnt, 0);
    chk(hold_err == 0, "R9 idle hold", hold_err, 0);
    frame(11, 32'h0001, "R8 after idle");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #800000;
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule